// File: doc/BRIEF.md
# Wired-OR Arbitration Competitor

This block is the logic half of a unit that contends for a shared backplane through a wired-OR arbitration bus made of eight number lines and one parity line. The unit holds a local arbitration number, loaded from an 8-bit input on a clock edge while the load enable is high. When told to compete, it drives that number onto the bus by binary countdown. It compares bits from the most significant downward. At the first position where the bus shows a 1 and the local number has a 0, the unit stops driving every lower bit. It wins when the settled bus equals its own number.

When it is not competing, the unit drives nothing. It then only compares its number with whatever the bus carries. A single result output means "greater than or equal" in that mode and "won" in compete mode. A registered copy of that output is updated on every clock. The block also checks the nine sensed lines for odd parity and flags the case where all eight number lines are asserted. A receive enable passes the sensed lines to the local receive outputs.

The bus is not modelled electrically. The unit emits a drive vector and takes in a sense vector, and the environment resolves the wired-OR between them.

Top module: `arbx_top`

## Requirements
- R1: On a rising clock edge with `num_le` high, the stored number takes the value of `num_in`. With `num_le` low, the stored number is unchanged.
- R2: With `compete` high and the sensed bus equal to the stored number, `bus_drive` equals the stored number. `bus_drive` never has a 1 where the stored number has a 0.
- R3: With `compete` high, find the highest bit where `bus_sense` is 1 and the stored number is 0. Every `bus_drive` bit below that position is 0. Bits at or above it follow the stored number.
- R4: With `compete` high, `bus_par_drive` is set so that `bus_drive` plus `bus_par_drive` has an odd number of ones. With `compete` low, both `bus_drive` and `bus_par_drive` are all zero.
- R5: With `compete` high, `win_ge` is 1 exactly when `bus_sense` equals the stored number.
- R6: With `compete` low, `win_ge` is 1 exactly when the stored number, read as unsigned, is greater than or equal to `bus_sense`.
- R7: `par_err` is 1 exactly when the nine sensed lines (`bus_sense` and `bus_par_sense`) hold an even number of ones.
- R8: `all_ones` is 1 exactly when all eight bits of `bus_sense` are 1.
- R9: With `rx_en` high, `rx_data` equals `bus_sense` and `rx_par` equals `bus_par_sense`. With `rx_en` low, both read as zero.
- R10: `win_ge_q` takes the value that `win_ge` had just before each rising clock edge outside reset.
- R11: A clock edge with `rst_n` low clears the stored number and `win_ge_q` to zero. While `rst_n` is low, `bus_drive` and `bus_par_drive` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| num_in | input | 8 | Arbitration number to load |
| num_le | input | 1 | Load enable for the stored number |
| compete | input | 1 | Take part in the competition |
| rx_en | input | 1 | Enable for the receive outputs |
| bus_sense | input | 8 | Resolved number lines of the bus |
| bus_par_sense | input | 1 | Resolved parity line of the bus |
| bus_drive | output | 8 | Number lines this unit asserts |
| bus_par_drive | output | 1 | Parity line this unit asserts |
| rx_data | output | 8 | Gated copy of the sensed number lines |
| rx_par | output | 1 | Gated copy of the sensed parity line |
| par_err | output | 1 | Odd parity check failed on the sensed lines |
| all_ones | output | 1 | All eight sensed number lines are asserted |
| win_ge | output | 1 | Win (compete) or greater-or-equal (compare) |
| win_ge_q | output | 1 | Registered copy of `win_ge` |

## Verification
Two things can happen in the same cycle: the load of a new number, and a compete or compare that still works on the old number. The bench makes them collide by asserting `num_le` together with `compete`, against a bus that the new number would win and the old one would lose. It then judges the drive and `win_ge` in that cycle against the old number, and the next cycle's behaviour against the new one. Parity errors and the all-ones status are also provoked while the unit is withdrawing, so that a corrupted sensed parity line cannot disturb the drive parity that the unit generates.

// File: rtl/arbx_pkg.sv
package arbx_pkg;

  localparam int unsigned ARBX_NUM_W = 8;

  typedef enum logic {
    ARBX_COMPARE = 1'b0,
    ARBX_COMPETE = 1'b1
  } arbx_mode_e;

endpackage

// File: rtl/arbx_num_store.sv
module arbx_num_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] num
);

  logic [W-1:0] num_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_r <= '0;
    end else if (load) begin
      num_r <= din;
    end
  end

  assign num = num_r;

endmodule

// File: rtl/arbx_contender.sv
module arbx_contender
  import arbx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         active,
  input  arbx_mode_e   mode,
  input  logic [W-1:0] num,
  input  logic [W-1:0] sense,
  output logic [W-1:0] drive,
  output logic         par_drive,
  output logic         withdrawn,
  output logic         result
);

  // Bits kept on the bus under binary countdown, MSB first.
  function automatic logic [W-1:0] countdown_keep(input logic [W-1:0] own,
                                                  input logic [W-1:0] seen);
    logic [W-1:0] keep;
    logic         out;
    keep = '0;
    out  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      keep[i] = own[i] & ~out;
      if (seen[i] && !own[i]) out = 1'b1;
    end
    return keep;
  endfunction

  function automatic logic any_loss(input logic [W-1:0] own,
                                    input logic [W-1:0] seen);
    return |(seen & ~own);
  endfunction

  logic           competing;
  logic [W-1:0]   keep;
  logic           ge_cmp;
  logic           eq_cmp;

  assign competing = active && (mode == ARBX_COMPETE);
  assign keep      = countdown_keep(num, sense);
  assign drive     = competing ? keep : '0;
  assign par_drive = competing ? ~(^keep) : 1'b0;
  assign withdrawn = competing && any_loss(num, sense);
  assign ge_cmp    = (num >= sense);
  assign eq_cmp    = (num == sense);
  assign result    = (mode == ARBX_COMPETE) ? eq_cmp : ge_cmp;

endmodule

// File: rtl/arbx_bus_status.sv
module arbx_bus_status #(
  parameter int unsigned W = 8
) (
  input  logic         rx_en,
  input  logic [W-1:0] sense,
  input  logic         par_sense,
  output logic [W-1:0] rx_data,
  output logic         rx_par,
  output logic         par_err,
  output logic         all_ones
);

  function automatic logic odd_count(input logic [W:0] lines);
    return ^lines;
  endfunction

  assign par_err  = ~odd_count({par_sense, sense});
  assign all_ones = &sense;
  assign rx_data  = rx_en ? sense : '0;
  assign rx_par   = rx_en & par_sense;

endmodule

// File: rtl/arbx_top.sv
module arbx_top
  import arbx_pkg::*;
#(
  parameter int unsigned W = ARBX_NUM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] num_in,
  input  logic         num_le,
  input  logic         compete,
  input  logic         rx_en,
  input  logic [W-1:0] bus_sense,
  input  logic         bus_par_sense,
  output logic [W-1:0] bus_drive,
  output logic         bus_par_drive,
  output logic [W-1:0] rx_data,
  output logic         rx_par,
  output logic         par_err,
  output logic         all_ones,
  output logic         win_ge,
  output logic         win_ge_q
);

  logic [W-1:0] num_q;
  arbx_mode_e   mode;
  logic         withdrawn;
  logic         result_r;

  assign mode = compete ? ARBX_COMPETE : ARBX_COMPARE;

  arbx_num_store #(.W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (num_le),
    .din   (num_in),
    .num   (num_q)
  );

  arbx_contender #(.W(W)) u_cont (
    .active    (rst_n),
    .mode      (mode),
    .num       (num_q),
    .sense     (bus_sense),
    .drive     (bus_drive),
    .par_drive (bus_par_drive),
    .withdrawn (withdrawn),
    .result    (win_ge)
  );

  arbx_bus_status #(.W(W)) u_stat (
    .rx_en     (rx_en),
    .sense     (bus_sense),
    .par_sense (bus_par_sense),
    .rx_data   (rx_data),
    .rx_par    (rx_par),
    .par_err   (par_err),
    .all_ones  (all_ones)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) result_r <= 1'b0;
    else        result_r <= win_ge;
  end

  assign win_ge_q = result_r;

endmodule

// File: rtl/arbx_checker.sv
module arbx_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] num_in,
  input logic         num_le,
  input logic         compete,
  input logic         rx_en,
  input logic [W-1:0] bus_sense,
  input logic [W-1:0] bus_drive,
  input logic         bus_par_drive,
  input logic [W-1:0] rx_data,
  input logic         rx_par,
  input logic         win_ge,
  input logic         win_ge_q,
  input logic [W-1:0] num_q,
  input logic         withdrawn
);

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    num_le |=> (num_q == $past(num_in)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!num_le && $past(rst_n)) |=> $stable(num_q));

  assert_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive & ~num_q) == '0);

  assert_withdraw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (compete && !withdrawn) |-> (bus_drive == num_q));

  assert_odd_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    compete |-> (^{bus_par_drive, bus_drive}));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !compete |-> (bus_drive == '0 && !bus_par_drive));

  assert_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (compete && win_ge) |-> (bus_drive == num_q && !withdrawn));

  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (rx_data == '0 && !rx_par));

  assert_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> (win_ge_q == $past(win_ge)));

  assert_reset_R11: assert property (@(posedge clk)
    !rst_n |=> (num_q == '0 && !win_ge_q));

  assert_reset_drive_R11: assert property (@(posedge clk)
    !rst_n |-> (bus_drive == '0 && !bus_par_drive));

  logic unused_sense;
  assign unused_sense = ^bus_sense;

endmodule

bind arbx_top arbx_checker #(.W(W)) u_arbx_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .num_in        (num_in),
  .num_le        (num_le),
  .compete       (compete),
  .rx_en         (rx_en),
  .bus_sense     (bus_sense),
  .bus_drive     (bus_drive),
  .bus_par_drive (bus_par_drive),
  .rx_data       (rx_data),
  .rx_par        (rx_par),
  .win_ge        (win_ge),
  .win_ge_q      (win_ge_q),
  .num_q         (num_q),
  .withdrawn     (withdrawn)
);

// File: tb/tb_arbx_top.sv
`timescale 1ns/1ps
module tb_arbx_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] num_in = '0;
  logic       num_le = 1'b0;
  logic       compete = 1'b0;
  logic       rx_en = 1'b0;
  logic [7:0] bus_sense = '0;
  logic       bus_par_sense = 1'b0;
  logic [7:0] bus_drive;
  logic       bus_par_drive;
  logic [7:0] rx_data;
  logic       rx_par;
  logic       par_err;
  logic       all_ones;
  logic       win_ge;
  logic       win_ge_q;

  int errors = 0;
  int checks = 0;
  logic [7:0] model_num = '0;
  logic       prev_exp = 1'b0;

  always #2.5 clk = ~clk;

  arbx_top dut (
    .clk(clk), .rst_n(rst_n), .num_in(num_in), .num_le(num_le),
    .compete(compete), .rx_en(rx_en), .bus_sense(bus_sense),
    .bus_par_sense(bus_par_sense), .bus_drive(bus_drive),
    .bus_par_drive(bus_par_drive), .rx_data(rx_data), .rx_par(rx_par),
    .par_err(par_err), .all_ones(all_ones), .win_ge(win_ge),
    .win_ge_q(win_ge_q)
  );

  function automatic logic [7:0] exp_drive(input logic [7:0] own,
                                           input logic [7:0] bus);
    logic [7:0] d = '0;
    logic gone = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      if (!gone) d[b] = own[b];
      if (bus[b] == 1'b1 && own[b] == 1'b0) gone = 1'b1;
    end
    return d;
  endfunction

  function automatic int ones(input logic [8:0] v);
    int n = 0;
    for (int b = 0; b < 9; b++) n += v[b];
    return n;
  endfunction

  function automatic logic [7:0] larger(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: check the register, apply inputs, check combinational outputs.
  task automatic step(input logic le, input logic [7:0] din, input logic comp,
                      input logic rxe, input logic [7:0] bus, input logic bpar);
    logic [7:0] ed;
    logic       ew;
    @(negedge clk);
    chk("R10 win_ge_q", win_ge_q, prev_exp);
    num_le = le; num_in = din; compete = comp; rx_en = rxe;
    bus_sense = bus; bus_par_sense = bpar;
    #1;
    ed = comp ? exp_drive(model_num, bus) : 8'h00;
    chk(comp ? "R3 drive" : "R4 release", bus_drive, ed);
    chk("R4 parity", bus_par_drive, comp ? ((ones({1'b0, ed}) % 2) == 0) : 1'b0);
    ew = comp ? (bus == model_num) : (model_num >= bus);
    chk(comp ? "R5 win" : "R6 ge", win_ge, ew);
    chk("R7 par_err", par_err, (ones({bpar, bus}) % 2) == 0);
    chk("R8 all_ones", all_ones, bus == 8'hFF);
    chk("R9 rx_data", rx_data, rxe ? bus : 8'h00);
    chk("R9 rx_par", rx_par, rxe ? bpar : 1'b0);
    prev_exp = ew;
    if (le) model_num = din;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] other;
    logic [7:0] bus;
    void'($urandom(32'h5EED_0A1B));
    compete = 1'b1;
    num_le = 1'b1; num_in = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset drive", bus_drive, 8'h00);
    chk("R11 reset par", bus_par_drive, 1'b0);
    chk("R11 reset q", win_ge_q, 1'b0);
    compete = 1'b0; num_le = 1'b0; bus_sense = '0; bus_par_sense = 1'b0;
    rst_n = 1'b1;
    prev_exp = 1'b1;   // stored number 0 >= bus 0 in compare mode
    model_num = 8'h00;
    // R11: stored number is zero after reset: compare against bus 1 fails
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'h01, 1'b0);
    // R1: load, then R2: compete alone on the bus
    step(1'b1, 8'h96, 1'b0, 1'b1, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b1, 8'h96, 1'b1);
    // R1: hold while load is low
    step(1'b0, 8'h11, 1'b1, 1'b0, 8'h96, 1'b1);
    // R3: loses at bit 6; lower bits withdrawn
    step(1'b0, 8'h00, 1'b1, 1'b1, 8'hC0, 1'b1);
    // load together with compete: this cycle still uses 0x96
    step(1'b1, 8'hF0, 1'b1, 1'b1, 8'hE0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b1, 8'hF0, 1'b1);
    // R8 all lines asserted, R7 with wrong and right parity
    step(1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1);
    // R6 equality boundary and extremes
    step(1'b1, 8'hFF, 1'b0, 1'b0, 8'hFF, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0);
    step(1'b1, 8'h00, 1'b1, 1'b1, 8'hFE, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic       le;
      logic       comp;
      logic [7:0] din;
      le    = ($urandom % 4) == 0;
      din   = 8'($urandom);
      comp  = ($urandom % 3) != 0;
      other = 8'($urandom);
      if (($urandom % 4) == 0) other = 8'h00;
      if (comp) bus = larger(model_num, other);
      else if (($urandom % 3) == 0) bus = model_num;
      else bus = other;
      step(le, din, comp, 1'($urandom), bus,
           (($urandom % 5) == 0) ? ~(^bus) : 1'(^bus ^ 1'b1) ^ 1'b1 ^ ~(^bus) ^ ~(^bus) ^ ~(^bus));
    end
    @(negedge clk);
    chk("R10 win_ge_q final", win_ge_q, prev_exp);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule